// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the time base for a pulse-width modulator. A free-running functional clock feeds a two-factor prescaler. The prescaler emits a one-clock tick enable, and each allowed tick advances a counter of `CNT_W` bits (16 by default). The counter can count up, count down, count up-down (triangle), or stay frozen. The counter's limit comes from an active period register. A period write can either replace that register at once or wait in a shadow copy until the counter next lands on zero.

A 16-bit control word sets the count mode, the two prescale factors, the period-load mode and the behaviour under a debug-halt request. The request can stop the count on the next tick, let the count finish its cycle at zero, or be ignored. Each time the counter advances, the block raises one-clock strobes when the new value is zero or equals the active period. Compare and output-action logic downstream use these strobes together with the count value. All register writes use a plain write-enable/data pair and take effect at the clock edge where the enable is high. Every decision made at that edge uses the register contents from before it.

Top module: `pwmtb_timebase`

## Requirements
- R1: With control bits [1:0] = 00 (up), each advance adds one, and the count goes to 0 on the advance after it reaches or exceeds the active period.
- R2: With control bits [1:0] = 01 (down), each advance subtracts one, and the count takes the active period on the advance after it reaches 0.
- R3: With control bits [1:0] = 10 (up-down), the count rises to the period and then falls to 0, turning at each end. `dir_down` shows the direction, and a period of 0 holds the count at 0.
- R4: With control bits [1:0] = 11 (freeze), the count and direction never change.
- R5: The counter advances once every D clocks, with D = H*2^C. C is control bits [12:10]. H is 1 when control bits [9:7] are 0 and twice their value otherwise.
- R6: Control bit 3 selects the period-load mode. When it is 0, a period write fills only the shadow, and the shadow moves into the active period on each advance that leaves the count at 0. When it is 1, a write fills both the active period and the shadow at the same edge.
- R7: `zero_evt` is high for exactly the one clock after an advance that leaves the count at 0. `prd_evt` is high for exactly the one clock after an advance that leaves the count equal to the active period. Neither strobe rises without an advance.
- R8: With control bits [15:14] = 00, any clock with `dbg_halt` high blocks the advance.
- R9: With control bits [15:14] = 01, `dbg_halt` blocks the advance only while the count is 0, so a halted counter runs on to the end of its cycle.
- R10: With control bit 15 = 1, `dbg_halt` has no effect.
- R11: Reset clears the count, the direction (up), both strobes, both period registers and the control word.
- R12: A control write restarts the prescaler, so the first tick after it comes D clocks later, using the new divisor.
- R13: When a period write and a zero reload fall on the same edge, an immediate write wins the active period. In shadow mode the active period takes the old shadow, and the new value waits in the shadow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write enable |
| ctl_wdata | input | 16 | Control word write data |
| prd_we | input | 1 | Period write enable |
| prd_wdata | input | CNT_W | Period write data |
| dbg_halt | input | 1 | Debug-halt request |
| count | output | CNT_W | Time-base counter value |
| dir_down | output | 1 | High while the counter is counting down |
| zero_evt | output | 1 | Strobe: advance landed on zero |
| prd_evt | output | 1 | Strobe: advance landed on the active period |

## Verification
A period write and the shadow-to-active reload at zero can fall on the same clock edge. So can a control write and a prescaler tick. The bench provokes the first collision by stepping its own model until the counter is one advance from wrapping, then issuing the write on exactly that clock, once in shadow mode and once in immediate mode. The count sequence that follows, and the period strobe it produces, show which value reached the active period. The control-write collision is provoked by rewriting the control word at a clock where a tick is due, so the sequence of advances must show the tick landing and the prescaler restarting at that same edge.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;

    localparam int CTL_W      = 16;
    localparam int PS_FIELD_W = 3;
    localparam int PS_FMAX    = (2 ** PS_FIELD_W) - 1;
    // largest divisor is (2*PS_FMAX) << PS_FMAX
    localparam int PS_W       = $clog2(2 * PS_FMAX) + PS_FMAX;

    typedef enum logic [1:0] {
        CM_UP     = 2'b00,
        CM_DOWN   = 2'b01,
        CM_UPDOWN = 2'b10,
        CM_FREEZE = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        RUN_HALT_NOW  = 2'b00,
        RUN_HALT_ZERO = 2'b01,
        RUN_FREE_ALT  = 2'b10,
        RUN_FREE      = 2'b11
    } run_mode_e;

    // control word layout, msb first
    typedef struct packed {
        run_mode_e              run;     // 15:14
        logic                   rsv13;   // 13
        logic [PS_FIELD_W-1:0]  cdiv;    // 12:10
        logic [PS_FIELD_W-1:0]  hsdiv;   // 9:7
        logic [2:0]             rsv6_4;  // 6:4
        logic                   prd_imm; // 3
        logic                   rsv2;    // 2
        cnt_mode_e              mode;    // 1:0
    } tb_ctl_t;

    // divisor minus one for the prescaler terminal count
    function automatic logic [PS_W-1:0] ps_div_m1(
        input logic [PS_FIELD_W-1:0] hs,
        input logic [PS_FIELD_W-1:0] cd
    );
        logic [PS_W-1:0] base;
        base = (hs == '0) ? PS_W'(1) : PS_W'({hs, 1'b0});
        return (base << cd) - PS_W'(1);
    endfunction

    function automatic logic halt_blocks(
        input run_mode_e run,
        input logic      halt,
        input logic      at_zero
    );
        logic blk;
        unique case (run)
            RUN_HALT_NOW:  blk = halt;
            RUN_HALT_ZERO: blk = halt && at_zero;
            default:       blk = 1'b0;
        endcase
        return blk;
    endfunction

endpackage

// File: rtl/pwmtb_prescale.sv
module pwmtb_prescale
    import pwmtb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  restart,
    input  logic [PS_FIELD_W-1:0] hsdiv,
    input  logic [PS_FIELD_W-1:0] cdiv,
    output logic                  tick
);

    logic [PS_W-1:0] pcnt;
    logic [PS_W-1:0] term;

    assign term = ps_div_m1(hsdiv, cdiv);
    assign tick = (pcnt >= term);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + PS_W'(1);
        end
    end

endmodule

// File: rtl/pwmtb_period.sv
module pwmtb_period #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         imm,
    input  logic         load_zero,
    output logic [W-1:0] prd_act,
    output logic [W-1:0] prd_act_nxt
);

    logic [W-1:0] prd_shd;
    logic [W-1:0] shd_nxt;

    always_comb begin
        prd_act_nxt = prd_act;
        shd_nxt     = prd_shd;
        if (load_zero) begin
            prd_act_nxt = prd_shd;
        end
        if (wr_en) begin
            shd_nxt = wr_data;
            if (imm) begin
                prd_act_nxt = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prd_act <= '0;
            prd_shd <= '0;
        end else begin
            prd_act <= prd_act_nxt;
            prd_shd <= shd_nxt;
        end
    end

endmodule

// File: rtl/pwmtb_counter.sv
module pwmtb_counter
    import pwmtb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  cnt_mode_e    mode,
    input  logic [W-1:0] prd,
    output logic [W-1:0] cnt,
    output logic         dir_dn,
    output logic [W-1:0] cnt_nxt
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] step_val;
    logic         step_dir;

    always_comb begin
        step_val = cnt;
        step_dir = dir_dn;
        unique case (mode)
            CM_UP: begin
                step_dir = 1'b0;
                step_val = (cnt >= prd) ? '0 : cnt + ONE;
            end
            CM_DOWN: begin
                step_dir = 1'b1;
                step_val = (cnt == '0) ? prd : cnt - ONE;
            end
            CM_UPDOWN: begin
                if (!dir_dn) begin
                    if (cnt >= prd) begin
                        step_dir = 1'b1;
                        step_val = (cnt == '0) ? '0 : cnt - ONE;
                    end else begin
                        step_val = cnt + ONE;
                    end
                end else begin
                    if (cnt == '0) begin
                        step_dir = 1'b0;
                        step_val = (prd == '0) ? '0 : ONE;
                    end else begin
                        step_val = cnt - ONE;
                    end
                end
            end
            default: begin
                step_val = cnt;
                step_dir = dir_dn;
            end
        endcase
    end

    assign cnt_nxt = adv ? step_val : cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            dir_dn <= 1'b0;
        end else if (adv) begin
            cnt    <= step_val;
            dir_dn <= step_dir;
        end
    end

endmodule

// File: rtl/pwmtb_timebase.sv
module pwmtb_timebase
    import pwmtb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             prd_we,
    input  logic [CNT_W-1:0] prd_wdata,
    input  logic             dbg_halt,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             zero_evt,
    output logic             prd_evt
);

    tb_ctl_t          ctl_q;
    tb_ctl_t          ctl_in;
    logic             unused_rsv;
    logic             tick_w;
    logic             stall;
    logic             adv;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] prd_act_w;
    logic [CNT_W-1:0] prd_nxt;
    logic             load_zero;
    logic [1:0]       mode_w;
    logic [1:0]       run_w;

    assign ctl_in     = tb_ctl_t'(ctl_wdata);
    assign unused_rsv = ^{ctl_q.rsv13, ctl_q.rsv6_4, ctl_q.rsv2};
    assign mode_w     = ctl_q.mode;
    assign run_w      = ctl_q.run;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q <= ctl_in;
        end
    end

    pwmtb_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (ctl_we),
        .hsdiv   (ctl_q.hsdiv),
        .cdiv    (ctl_q.cdiv),
        .tick    (tick_w)
    );

    assign stall = halt_blocks(ctl_q.run, dbg_halt, count == '0);
    assign adv   = tick_w && !stall && (ctl_q.mode != CM_FREEZE);

    pwmtb_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .mode    (ctl_q.mode),
        .prd     (prd_act_w),
        .cnt     (count),
        .dir_dn  (dir_down),
        .cnt_nxt (cnt_nxt)
    );

    assign load_zero = adv && (cnt_nxt == '0);

    pwmtb_period #(.W(CNT_W)) u_prd (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (prd_we),
        .wr_data     (prd_wdata),
        .imm         (ctl_q.prd_imm),
        .load_zero   (load_zero),
        .prd_act     (prd_act_w),
        .prd_act_nxt (prd_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_evt <= 1'b0;
            prd_evt  <= 1'b0;
        end else begin
            zero_evt <= load_zero;
            prd_evt  <= adv && (cnt_nxt == prd_nxt);
        end
    end

endmodule

// File: rtl/pwmtb_timebase_chk.sv
module pwmtb_timebase_chk
    import pwmtb_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   mode,
    input logic [1:0]   run,
    input logic         dbg_halt,
    input logic         tick,
    input logic [W-1:0] prd_act,
    input logic [W-1:0] count,
    input logic         zero_evt,
    input logic         prd_evt
);

    a_r7_zero_strobe: assert property (@(posedge clk) disable iff (rst)
        zero_evt |-> (count == '0));

    a_r7_prd_strobe: assert property (@(posedge clk) disable iff (rst)
        prd_evt |-> (count == prd_act));

    a_r4_freeze_holds: assert property (@(posedge clk) disable iff (rst)
        (mode == CM_FREEZE) |=> $stable(count));

    a_r8_halt_now: assert property (@(posedge clk) disable iff (rst)
        (dbg_halt && run == RUN_HALT_NOW) |=> $stable(count));

    a_r9_halt_at_zero: assert property (@(posedge clk) disable iff (rst)
        (dbg_halt && run == RUN_HALT_ZERO && count == '0) |=> $stable(count));

    a_r1_up_step: assert property (@(posedge clk) disable iff (rst)
        (mode == CM_UP) |=>
            ((count == $past(count) + W'(1)) || (count == '0) || $stable(count)));

    a_r10_free_run: assert property (@(posedge clk) disable iff (rst)
        (run[1] && tick && mode == CM_UP && prd_act != '0) |=> !$stable(count));

endmodule

bind pwmtb_timebase pwmtb_timebase_chk #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode_w),
    .run      (run_w),
    .dbg_halt (dbg_halt),
    .tick     (tick_w),
    .prd_act  (prd_act_w),
    .count    (count),
    .zero_evt (zero_evt),
    .prd_evt  (prd_evt)
);

// File: tb/pwmtb_timebase_bench.sv
module pwmtb_timebase_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ctl_we = 1'b0;
    logic [15:0]  ctl_wdata = '0;
    logic         prd_we = 1'b0;
    logic [W-1:0] prd_wdata = '0;
    logic         dbg_halt = 1'b0;
    logic [W-1:0] count;
    logic         dir_down;
    logic         zero_evt;
    logic         prd_evt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // expected {count, dir_down, zero_evt, prd_evt}
    logic [W+2:0] q_exp[$];
    string        q_req[$];

    // bench model state
    logic [15:0]  m_ctl = '0;
    int           m_pre = 0;
    logic [W-1:0] m_cnt = '0;
    logic         m_dir = 1'b0;
    logic [W-1:0] m_act = '0;
    logic [W-1:0] m_shd = '0;

    always #2.5 clk = ~clk;

    pwmtb_timebase #(.CNT_W(W)) u_pwmtb_timebase (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .prd_we    (prd_we),
        .prd_wdata (prd_wdata),
        .dbg_halt  (dbg_halt),
        .count     (count),
        .dir_down  (dir_down),
        .zero_evt  (zero_evt),
        .prd_evt   (prd_evt)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // predicts the state after the coming clock edge (R5, R6, R12, R13)
    task automatic model_edge(input logic cwe, input logic [15:0] cd,
                              input logic pwe, input logic [W-1:0] pd,
                              input logic halt, input string req);
        int           hs, div;
        logic         tick, stall, adv, ze, pe;
        logic [W-1:0] nc, na, ns;
        logic         nd;
        hs    = int'(m_ctl[9:7]);
        div   = ((hs == 0) ? 1 : 2 * hs) * (1 << int'(m_ctl[12:10]));
        tick  = (m_pre >= div - 1);
        stall = 1'b0;
        if (m_ctl[15:14] == 2'b00) stall = halt;
        if (m_ctl[15:14] == 2'b01) stall = halt && (m_cnt == 0);
        adv   = tick && !stall && (m_ctl[1:0] != 2'b11);
        nc = m_cnt;
        nd = m_dir;
        if (adv) begin
            case (m_ctl[1:0])
                2'b00: begin nd = 1'b0; nc = (m_cnt >= m_act) ? '0 : m_cnt + 1'b1; end
                2'b01: begin nd = 1'b1; nc = (m_cnt == 0) ? m_act : m_cnt - 1'b1; end
                default: begin
                    if (!m_dir && m_cnt < m_act) nc = m_cnt + 1'b1;
                    else if (!m_dir) begin nd = 1'b1; nc = (m_cnt == 0) ? '0 : m_cnt - 1'b1; end
                    else if (m_cnt != 0) nc = m_cnt - 1'b1;
                    else begin nd = 1'b0; nc = (m_act == 0) ? '0 : W'(1); end
                end
            endcase
        end
        na = m_act;
        ns = m_shd;
        if (adv && nc == 0) na = m_shd;
        if (pwe) begin
            ns = pd;
            if (m_ctl[3]) na = pd;
        end
        ze = adv && (nc == 0);
        pe = adv && (nc == na);
        m_pre = (cwe || tick) ? 0 : m_pre + 1;
        if (cwe) m_ctl = cd;
        m_cnt = nc;
        m_dir = nd;
        m_act = na;
        m_shd = ns;
        q_exp.push_back({nc, nd, ze, pe});
        q_req.push_back(req);
    endtask

    // called at a falling edge; drives one clock of stimulus
    task automatic step(input string req, input logic cwe, input logic [15:0] cd,
                        input logic pwe, input logic [W-1:0] pd, input logic halt);
        ctl_we    = cwe;
        ctl_wdata = cd;
        prd_we    = pwe;
        prd_wdata = pd;
        dbg_halt  = halt;
        model_edge(cwe, cd, pwe, pd, halt, req);
        @(negedge clk);
    endtask

    task automatic idle(input string req, input int n, input logic halt);
        for (int i = 0; i < n; i++) step(req, 1'b0, '0, 1'b0, '0, halt);
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #1;
        if (q_exp.size() > 0) begin
            logic [W+2:0] e;
            string        r;
            e = q_exp.pop_front();
            r = q_req.pop_front();
            chk(r, "count", 32'(count), 32'(e[W+2:3]));
            chk(r, "dir_down", 32'(dir_down), 32'(e[2]));
            chk(r, "zero_evt", 32'(zero_evt), 32'(e[1]));
            chk(r, "prd_evt", 32'(prd_evt), 32'(e[0]));
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk("R11", "count", 32'(count), 32'd0);
        chk("R11", "dir_down", 32'(dir_down), 32'd0);
        chk("R11", "zero_evt", 32'(zero_evt), 32'd0);
        chk("R11", "prd_evt", 32'(prd_evt), 32'd0);
        rst = 1'b0;
        // R11: zero period after reset pins the count at 0 with both strobes
        idle("R11", 4, 1'b0);

        // R1/R6: up mode, immediate load, free run
        step("R6", 1'b1, 16'hC008, 1'b0, '0, 1'b0);
        step("R6", 1'b0, '0, 1'b1, 16'd5, 1'b0);
        idle("R1", 20, 1'b0);
        // R2: down mode
        step("R2", 1'b1, 16'hC009, 1'b0, '0, 1'b0);
        idle("R2", 20, 1'b0);
        // R3: up-down mode
        step("R3", 1'b1, 16'hC00A, 1'b0, '0, 1'b0);
        idle("R3", 26, 1'b0);
        // R4: freeze
        step("R4", 1'b1, 16'hC00B, 1'b0, '0, 1'b0);
        idle("R4", 8, 1'b0);

        // R5: divisor 2*3 * 2^1 = 12, then 1 * 2^2 = 4
        step("R5", 1'b1, 16'hC588, 1'b0, '0, 1'b0);
        idle("R5", 80, 1'b0);
        step("R5", 1'b1, 16'hC808, 1'b0, '0, 1'b0);
        idle("R5", 9, 1'b0);
        // R12: rewrite control mid-division, prescaler restarts
        step("R12", 1'b1, 16'hC808, 1'b0, '0, 1'b0);
        idle("R12", 2, 1'b0);
        step("R12", 1'b1, 16'hC808, 1'b0, '0, 1'b0);
        idle("R12", 14, 1'b0);
        // R12: control write on a tick edge (divisor 4)
        while (m_pre != 3) idle("R12", 1, 1'b0);
        step("R12", 1'b1, 16'hC808, 1'b0, '0, 1'b0);
        idle("R12", 10, 1'b0);

        // R6: shadow mode, new period waits for zero
        step("R6", 1'b1, 16'hC000, 1'b0, '0, 1'b0);
        idle("R6", 2, 1'b0);
        step("R6", 1'b0, '0, 1'b1, 16'd9, 1'b0);
        idle("R6", 30, 1'b0);

        // R13: shadow write on the wrap edge
        while (m_cnt != m_act) idle("R13", 1, 1'b0);
        step("R13", 1'b0, '0, 1'b1, 16'd3, 1'b0);
        idle("R13", 25, 1'b0);
        // R13: immediate write on the wrap edge
        step("R13", 1'b1, 16'hC008, 1'b0, '0, 1'b0);
        while (m_cnt != m_act) idle("R13", 1, 1'b0);
        step("R13", 1'b0, '0, 1'b1, 16'd7, 1'b0);
        idle("R13", 20, 1'b0);

        // R8: stop at once
        step("R8", 1'b1, 16'h0008, 1'b0, '0, 1'b0);
        idle("R8", 3, 1'b0);
        idle("R8", 10, 1'b1);
        idle("R8", 5, 1'b0);
        // R9: finish cycle, stop at zero
        step("R9", 1'b1, 16'h4008, 1'b0, '0, 1'b0);
        idle("R9", 2, 1'b0);
        idle("R9", 16, 1'b1);
        idle("R9", 5, 1'b0);
        // R10: halt ignored in both free-run codes
        step("R10", 1'b1, 16'hC008, 1'b0, '0, 1'b0);
        idle("R10", 12, 1'b1);
        step("R10", 1'b1, 16'h8009, 1'b0, '0, 1'b1);
        idle("R10", 12, 1'b1);
        idle("R10", 3, 1'b0);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule